// File: doc/BRIEF.md
# Fractional Square-Wave Clock Divider

This block turns a stable reference clock into a 32.768 kHz square wave whose phase never drifts. The reference can be 10 MHz or 5 MHz. A prescaler passes one reference cycle in four as a tick. A half-period timer counts these ticks. The output toggles when the count reaches the half length chosen for the current half period.

The ideal half period is not a whole number of ticks. It is 38.147 ticks for a 10 MHz reference and 19.073 ticks for a 5 MHz reference. A 12-bit phase accumulator tracks the fractional remainder. When it wraps, the next half period is one tick longer than the base length. The accumulator starts at half scale, so every edge lands on the tick nearest its ideal position. The edge error is therefore never more than half a tick. After a full cycle of the accumulator, the total error is exactly zero.

A one-cycle strobe marks each output transition. Downstream logic can use this strobe as an event instead of detecting edges on the square wave. The reference selection is captured while reset is held.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sq_out` and `tgl_strobe` are both low. Asserting `rst` at any time restarts the edge sequence from the beginning.
- R2: A tick occurs on one clock cycle in every four. Toggles happen only on ticks, so the number of clock cycles between consecutive toggles is always a multiple of four.
- R3: With `ref_sel` = 0 (10 MHz reference), every half period is 38 or 39 ticks long, which is 152 or 156 clock cycles.
- R4: With `ref_sel` = 1 (5 MHz reference), every half period is 19 or 20 ticks long, which is 76 or 80 clock cycles.
- R5: Count the posedges after reset release from 0. Toggle number k (k ≥ 1) appears at posedge index 4·floor((k·Q + 2048)/4096) − 1. Q is 156250 for `ref_sel` = 0 and 78125 for `ref_sel` = 1. Each edge is therefore the tick nearest the ideal edge, with at most half a tick of error. In the 10 MHz mode this gives exactly 65,536 toggles in every 10,000,000 reference cycles.
- R6: The length of the first half period is fixed during reset: 38 ticks for `ref_sel` = 0 and 19 ticks for `ref_sel` = 1. The first toggle occurs exactly on that tick.
- R7: `tgl_strobe` is high for exactly the clock cycles in which `sq_out` has just taken a new value, and low at all other times.
- R8: `ref_sel` is sampled only while `rst` is high. Changing it during operation has no effect on the edge positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (10 MHz or 5 MHz in the application) |
| rst | input | 1 | Synchronous active-high reset; captures `ref_sel` |
| ref_sel | input | 1 | Reference rate select: 0 = 10 MHz, 1 = 5 MHz |
| sq_out | output | 1 | 32.768 kHz square wave, low after reset |
| tgl_strobe | output | 1 | One-cycle pulse in each cycle where `sq_out` has just changed |

## Verification
The assertions assume that `rst` has a known value from the first clock edge and is held for at least one edge before release. The tick and half-length properties are disabled during reset, so these checks do not depend on what the registers held before reset. The bench drives `rst` high at time zero and holds it for three edges on every restart. The assertions make no assumption about `ref_sel`. The bench therefore toggles it freely during operation to show that the latched mode stays fixed, and it changes `ref_sel` only on falling clock edges.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    // Accumulator width: 4096 steps per tick of fractional phase.
    localparam int FD_ACC_W    = 12;
    // Half-period length field width (holds up to 127 ticks).
    localparam int FD_LEN_W    = 7;
    // Half-scale seed makes each carry a round-to-nearest decision.
    localparam int FD_ACC_HALF = 1 << (FD_ACC_W - 1);

    typedef enum logic {
        REF_FAST = 1'b0,   // 10 MHz reference
        REF_SLOW = 1'b1    // 5 MHz reference
    } ref_mode_e;

    typedef struct packed {
        logic [FD_LEN_W-1:0] len;   // ticks in the half period being timed
        logic [FD_ACC_W-1:0] acc;   // fractional phase after that half period
    } half_plan_t;

    // Advance the fractional phase by one half period and derive its length.
    function automatic half_plan_t fd_plan_next(
        input logic [FD_ACC_W-1:0] acc,
        input logic [FD_LEN_W-1:0] base,
        input logic [FD_ACC_W-1:0] inc
    );
        logic [FD_ACC_W:0] sum;
        half_plan_t        plan;
        sum      = {1'b0, acc} + {1'b0, inc};
        plan.acc = sum[FD_ACC_W-1:0];
        plan.len = base + {{(FD_LEN_W-1){1'b0}}, sum[FD_ACC_W]};
        return plan;
    endfunction

endpackage

// File: rtl/fd_prescaler.sv
module fd_prescaler #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_count
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
            logic [CNT_W-1:0] div_cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    div_cnt <= '0;
                end else if (div_cnt == LAST) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end

            assign tick = (div_cnt == LAST);

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);  // R2
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/fd_phase_acc.sv
module fd_phase_acc
    import frac_div_pkg::*;
#(
    parameter int BASE_FAST = 38,
    parameter int INC_FAST  = 602,
    parameter int BASE_SLOW = 19,
    parameter int INC_SLOW  = 301
) (
    input  logic                clk,
    input  logic                rst,
    input  ref_mode_e           mode_in,
    input  logic                advance,
    output logic [FD_LEN_W-1:0] half_len
);
    localparam logic [FD_LEN_W-1:0] B_FAST = FD_LEN_W'(BASE_FAST);
    localparam logic [FD_LEN_W-1:0] B_SLOW = FD_LEN_W'(BASE_SLOW);
    localparam logic [FD_ACC_W-1:0] I_FAST = FD_ACC_W'(INC_FAST);
    localparam logic [FD_ACC_W-1:0] I_SLOW = FD_ACC_W'(INC_SLOW);
    localparam logic [FD_ACC_W-1:0] SEED   = FD_ACC_W'(FD_ACC_HALF);

    ref_mode_e           mode_q;
    half_plan_t          plan_q;
    half_plan_t          seed_plan;
    half_plan_t          step_plan;
    logic [FD_LEN_W-1:0] base_in, base_q;
    logic [FD_ACC_W-1:0] inc_in, inc_q;

    always_comb begin
        base_in = (mode_in == REF_SLOW) ? B_SLOW : B_FAST;
        inc_in  = (mode_in == REF_SLOW) ? I_SLOW : I_FAST;
        base_q  = (mode_q  == REF_SLOW) ? B_SLOW : B_FAST;
        inc_q   = (mode_q  == REF_SLOW) ? I_SLOW : I_FAST;
    end

    // The first half period is planned while reset is held; later ones are
    // planned at each toggle, one full half period before they are needed.
    always_comb begin
        seed_plan = fd_plan_next(SEED, base_in, inc_in);
        step_plan = fd_plan_next(plan_q.acc, base_q, inc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_in;
            plan_q <= seed_plan;
        end else if (advance) begin
            plan_q <= step_plan;
        end
    end

    assign half_len = plan_q.len;

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));  // R8

    AST_LEN_PAIR: assert property (@(posedge clk) disable iff (rst)
        (half_len == base_q) || (half_len == base_q + 1'b1));  // R3

endmodule

// File: rtl/fd_half_timer.sv
module fd_half_timer
    import frac_div_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [FD_LEN_W-1:0] half_len,
    output logic                advance
);
    logic [FD_LEN_W-1:0] tick_cnt;
    logic                at_end;

    assign at_end  = (tick_cnt == half_len - 1'b1);
    assign advance = tick && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (advance) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        tick_cnt < half_len);  // R3

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int TICK_DIV  = 4,
    parameter int BASE_FAST = 38,
    parameter int INC_FAST  = 602,
    parameter int BASE_SLOW = 19,
    parameter int INC_SLOW  = 301
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_sel,
    output logic sq_out,
    output logic tgl_strobe
);
    logic                tick;
    logic                advance;
    logic [FD_LEN_W-1:0] half_len;
    ref_mode_e           mode_in;

    assign mode_in = ref_sel ? REF_SLOW : REF_FAST;

    fd_prescaler #(
        .TICK_DIV (TICK_DIV)
    ) u_prescaler (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fd_phase_acc #(
        .BASE_FAST (BASE_FAST),
        .INC_FAST  (INC_FAST),
        .BASE_SLOW (BASE_SLOW),
        .INC_SLOW  (INC_SLOW)
    ) u_phase_acc (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_in),
        .advance  (advance),
        .half_len (half_len)
    );

    fd_half_timer u_half_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .half_len (half_len),
        .advance  (advance)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_out     <= 1'b0;
            tgl_strobe <= 1'b0;
        end else begin
            tgl_strobe <= advance;
            if (advance) begin
                sq_out <= ~sq_out;
            end
        end
    end

    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        rst |=> (!sq_out && !tgl_strobe));  // R1

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (sq_out != $past(sq_out)) |-> tgl_strobe);  // R7

    AST_STROBE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
        tgl_strobe |-> (sq_out != $past(sq_out)));  // R7

    AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        tgl_strobe |-> $past(tick));  // R2

endmodule

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_sel = 1'b0;
    logic sq_out;
    logic tgl_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    frac_clk_div u_frac_clk_div (
        .clk        (clk),
        .rst        (rst),
        .ref_sel    (ref_sel),
        .sq_out     (sq_out),
        .tgl_strobe (tgl_strobe)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: outputs held low during reset, also after running.
    task automatic t_reset_quiet(input logic sel);
        @(negedge clk);
        ref_sel = sel;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(sq_out == 1'b0, "R1 sq_out in reset", sq_out, 0);
        check(tgl_strobe == 1'b0, "R1 strobe in reset", tgl_strobe, 0);
    endtask

    // Release reset with sel latched, follow nedges toggles and check each.
    // After flip_at toggles, ref_sel is inverted (R8: must not matter).
    task automatic t_run(input logic sel, input int nedges, input int flip_at);
        longint q        = sel ? 78125 : 156250;
        int     base     = sel ? 19 : 38;
        string  len_tag  = sel ? "R4 half length" : "R3 half length";
        int     idx      = -1;
        int     k        = 0;
        longint prev_e   = -1;
        int     strobe_bad = 0;
        int     mult_bad = 0;
        logic   prev_sq;
        t_reset_quiet(sel);
        rst = 1'b0;
        prev_sq = sq_out;
        while (k < nedges && idx < 150000) begin
            @(posedge clk);
            idx++;
            @(negedge clk);
            if (k >= flip_at) ref_sel = ~sel;
            if (idx == 0) begin
                check(sq_out == 1'b0 && tgl_strobe == 1'b0, "R1 first cycle after reset",
                      {sq_out, tgl_strobe}, 0);
            end
            if ((sq_out != prev_sq) != tgl_strobe) strobe_bad++;
            if (sq_out != prev_sq) begin
                longint exp_e;
                longint d;
                k++;
                exp_e = 4 * ((longint'(k) * q + 2048) / 4096) - 1;
                d = idx - prev_e;
                if (k == 1) begin
                    check(idx == 4 * base - 1, "R6 first toggle", idx, 4 * base - 1);
                end
                if (k > flip_at) begin
                    check(idx == exp_e, "R8 edge after ref_sel change", idx, exp_e);
                end else begin
                    check(idx == exp_e, "R5 edge position", idx, exp_e);
                end
                check(d == 4 * base || d == 4 * (base + 1), len_tag, d, 4 * base);
                if (d % 4 != 0) mult_bad++;
                prev_e = idx;
            end
            prev_sq = sq_out;
        end
        check(k == nedges, "R5 toggle count", k, nedges);
        check(strobe_bad == 0, "R7 strobe matches change", strobe_bad, 0);
        check(mult_bad == 0, "R2 toggles on tick grid", mult_bad, 0);
        ref_sel = sel;
    endtask

    initial begin
        t_reset_quiet(1'b0);         // R1 at power-up
        t_run(1'b0, 500, 1000000);   // R3 R5 R6 R7 R2 in 10 MHz mode
        t_run(1'b1, 500, 1000000);   // R4 R5 R6 R1 restart in 5 MHz mode
        t_run(1'b0, 100, 20);        // R8 ref_sel changed while running
        t_reset_quiet(1'b1);         // R1 reset after activity
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule